// File: doc/BRIEF.md
# Display Backlight PWM Controller

This block drives one backlight pin with a pulse-width-modulated waveform. A small synchronous register port sets four things: an on/off bit, a clock prescaler, the length of one PWM cycle in prescaled ticks, and the number of ticks at the start of each cycle during which the pin is high. A write is taken on any clock edge where the write strobe is high. Reads are combinational from the address.

The prescaler, period and high-width settings are double-buffered. Software writes the shadow copies, which read back at once but do not affect the pin. A rising edge of the commit bit then copies the shadow set into a staging set. While the output is running, the staging set becomes active only at the next PWM cycle boundary, so a cycle is never cut short. While the output is off, the staging set becomes active on the following clock.

The high-width field is one bit wider than the period field. Any high width larger than the period therefore gives a constant high level, and a high width of zero gives a constant low level.

Top module: `bl_pwm`

## Requirements
- R1: After reset every register reads 0, and `pwm_out` is low.
- R2: Register map (byte offsets). 0x00 bit 0 is the run bit. 0x08 bit 0 is the commit bit and reads back the last value written to it. 0x10 bits [25:16] are the prescaler. 0x14 bits [11:0] are the period and bits [28:16] are the high width. Reads return the shadow values. Unmapped bits and addresses read 0, and writes to them are ignored.
- R3: While the run bit is 0, `pwm_out` is low. The output is already low at the sample taken after the write that clears the bit, and the counters are held at zero.
- R4: Each tick lasts (prescaler + 1) clock cycles.
- R5: One PWM cycle lasts (period + 1) ticks, and the waveform repeats with that length.
- R6: The output is high for the first `high` ticks of every cycle and low for the rest. A high width of 0 keeps the output constantly low.
- R7: A high width of (period + 1) or more keeps the output constantly high.
- R8: A write to the prescaler, period or high-width field does not change the waveform until a commit occurs.
- R9: Only a 0-to-1 change of the commit bit commits. Writing 1 again while the bit already holds 1 has no effect.
- R10: A commit made while the output is running finishes the current PWM cycle with the old settings and starts the next cycle with the new ones.
- R11: A commit made while the output is off makes the new settings active before the next write can set the run bit, so the first enabled cycle uses them.
- R12: When the run bit goes from 0 to 1, the prescaler and the period count both start from zero. The first cycle therefore begins with its full high phase, even when the output was stopped partway through a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (5) | Register byte address |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from `bus_addr` |
| pwm_out | output | 1 | PWM output |

## Verification
Read data follows the address in the same cycle. The bench checks it 1 ns after a falling edge, with the write strobe low.

A write to the run bit changes `pwm_out` right after the write's rising edge. The expected waveform is therefore queued in the cycle the write task returns, and one sample is compared every falling edge after that.

A commit made while the output is off becomes active two edges after the commit write. A commit made while the output runs becomes active at the cycle boundary. In the running case the bench fixes the commit edge with a drain-then-write sequence whose position in the cycle is known. It queues the remainder of the old cycle, then the new pattern.

// File: rtl/bl_pwm.sv
module bl_pwm #(
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int DIV_W   = 10,
  parameter int PER_W   = 12,
  parameter int HW_W    = 13,
  parameter int DIV_LSB = 16,
  parameter int HW_LSB  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          pwm_out
);
  localparam logic [AW-1:0] A_RUN = AW'('h00);
  localparam logic [AW-1:0] A_CMT = AW'('h08);
  localparam logic [AW-1:0] A_DIV = AW'('h10);
  localparam logic [AW-1:0] A_PER = AW'('h14);

  logic             en_q, cmt_q, pend_q;
  logic [DIV_W-1:0] div_s, div_p, div_a, pre_cnt;
  logic [PER_W-1:0] per_s, per_p, per_a, per_cnt;
  logic [HW_W-1:0]  hw_s, hw_p, hw_a;

  logic wr_run, wr_cmt, wr_div, wr_per, commit, tick, wrap, apply;
  logic unused_wbits;

  assign wr_run = bus_we && (bus_addr == A_RUN);
  assign wr_cmt = bus_we && (bus_addr == A_CMT);
  assign wr_div = bus_we && (bus_addr == A_DIV);
  assign wr_per = bus_we && (bus_addr == A_PER);

  assign commit = wr_cmt && bus_wdata[0] && !cmt_q;
  assign tick   = (pre_cnt == div_a);
  assign wrap   = tick && (per_cnt == per_a);
  assign apply  = pend_q && (!en_q || wrap);
  assign unused_wbits = ^bus_wdata;

  // control and shadow registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cmt_q <= 1'b0;
      div_s <= '0;
      per_s <= '0;
      hw_s  <= '0;
    end else begin
      if (wr_run) en_q  <= bus_wdata[0];
      if (wr_cmt) cmt_q <= bus_wdata[0];
      if (wr_div) div_s <= bus_wdata[DIV_LSB +: DIV_W];
      if (wr_per) begin
        per_s <= bus_wdata[PER_W-1:0];
        hw_s  <= bus_wdata[HW_LSB +: HW_W];
      end
    end
  end

  // staging and active sets
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      div_p  <= '0;
      per_p  <= '0;
      hw_p   <= '0;
      div_a  <= '0;
      per_a  <= '0;
      hw_a   <= '0;
    end else begin
      if (apply) begin
        div_a <= div_p;
        per_a <= per_p;
        hw_a  <= hw_p;
      end
      if (commit) begin
        div_p  <= div_s;
        per_p  <= per_s;
        hw_p   <= hw_s;
        pend_q <= 1'b1;
      end else if (apply) begin
        pend_q <= 1'b0;
      end
    end
  end

  // prescaler and period counter
  always_ff @(posedge clk) begin
    if (!rst_n || !en_q) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      per_cnt <= wrap ? '0 : per_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign pwm_out = en_q && (HW_W'(per_cnt) < hw_a);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RUN: bus_rdata[0] = en_q;
      A_CMT: bus_rdata[0] = cmt_q;
      A_DIV: bus_rdata[DIV_LSB +: DIV_W] = div_s;
      A_PER: begin
        bus_rdata[PER_W-1:0]       = per_s;
        bus_rdata[HW_LSB +: HW_W]  = hw_s;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int AW    = 5,
  parameter int DW    = 32,
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HW_W  = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [DW-1:0]    bus_wdata,
  input logic             pwm_out,
  input logic             en_q,
  input logic [DIV_W-1:0] pre_cnt,
  input logic [DIV_W-1:0] div_a,
  input logic [PER_W-1:0] per_cnt,
  input logic [PER_W-1:0] per_a,
  input logic [HW_W-1:0]  hw_a
);
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0 && !bus_wdata[0]) |=> !pwm_out); // R3

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (pre_cnt <= div_a)); // R4

  AST_PER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (per_cnt <= per_a)); // R5

  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_a == '0) |-> !pwm_out); // R6

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && hw_a > HW_W'(per_a)) |-> pwm_out); // R7

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && (pre_cnt != '0 || per_cnt != '0)) |-> $stable({div_a, per_a, hw_a})); // R10

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_q) && hw_a != '0) |-> (pwm_out && per_cnt == '0 && pre_cnt == '0)); // R12
endmodule

bind bl_pwm bl_pwm_chk #(
  .AW(AW), .DW(DW), .DIV_W(DIV_W), .PER_W(PER_W), .HW_W(HW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pwm_out(pwm_out), .en_q(en_q),
  .pre_cnt(pre_cnt), .div_a(div_a), .per_cnt(per_cnt), .per_a(per_a),
  .hw_a(hw_a)
);

// File: tb/bl_pwm_tb.sv
`timescale 1ns/1ps
module bl_pwm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { logic v; string r; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  bl_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(logic [4:0] a, logic [31:0] exp, string req);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic push_const(logic v, int n, string req);
    for (int i = 0; i < n; i++) q.push_back('{v, req});
  endtask

  // expected waveform, starting at clock j0 of the first PWM cycle
  task automatic push_pat(int dv, int pr, int hw, int j0, int ncyc, string req);
    for (int c = 0; c < ncyc; c++)
      for (int j = (c == 0 ? j0 : 0); j < (pr + 1) * (dv + 1); j++)
        q.push_back('{((j / (dv + 1)) < hw), req});
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic cfg(int dv, int pr, int hw);
    wr(5'h10, 32'(dv) << 16);
    wr(5'h14, (32'(hw) << 16) | 32'(pr));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: one expected sample per falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(it.r, {31'b0, pwm_out}, {31'b0, it.v});
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk(5'h00, 0, "R1");
    rd_chk(5'h08, 0, "R1");
    rd_chk(5'h10, 0, "R1");
    rd_chk(5'h14, 0, "R1");
    check("R1", {31'b0, pwm_out}, 0);

    // R2 readback and unused bits
    wr(5'h00, 32'hFFFF_FFFF); rd_chk(5'h00, 32'h1, "R2");
    wr(5'h00, 32'h0);         rd_chk(5'h00, 32'h0, "R2");
    wr(5'h10, 32'hFFFF_FFFF); rd_chk(5'h10, 32'h03FF_0000, "R2");
    wr(5'h14, 32'hFFFF_FFFF); rd_chk(5'h14, 32'h1FFF_0FFF, "R2");
    wr(5'h08, 32'hFFFF_FFFF); rd_chk(5'h08, 32'h1, "R2");
    wr(5'h08, 32'h0);         rd_chk(5'h08, 32'h0, "R2");
    wr(5'h04, 32'hFFFF_FFFF); rd_chk(5'h04, 32'h0, "R2");

    // R11 commit while off, R3 held low while off
    cfg(1, 9, 4);
    wr(5'h08, 1); wr(5'h08, 0);
    push_const(0, 20, "R3");
    drain();

    // R12 R4 R5 R6: run config A; R8 shadow writes during run
    wr(5'h00, 1);
    push_pat(1, 9, 4, 0, 3, "R4/R5/R6/R11/R12");
    cfg(0, 5, 3);
    drain();
    // R8 cycle 4 still uses A; R10 commit lands at clock 1 of cycle 4
    wr(5'h08, 1);
    push_pat(1, 9, 4, 2, 1, "R8/R10");
    push_pat(0, 5, 3, 0, 3, "R10");
    wr(5'h08, 0);
    drain();

    // R3 stop
    wr(5'h00, 0);
    push_const(0, 10, "R3");
    drain();

    // R7 high width = period + 1, then maximum
    cfg(0, 4, 5); wr(5'h08, 1); wr(5'h08, 0);
    wr(5'h00, 1); push_const(1, 20, "R7"); drain();
    wr(5'h00, 0);
    cfg(1, 4, 13'h1FFF); wr(5'h08, 1); wr(5'h08, 0);
    wr(5'h00, 1); push_const(1, 20, "R7"); drain();
    wr(5'h00, 0);

    // R6 zero high width
    cfg(2, 3, 0); wr(5'h08, 1); wr(5'h08, 0);
    wr(5'h00, 1); push_const(0, 24, "R6"); drain();
    wr(5'h00, 0);

    // R9 writing 1 while commit already holds 1
    cfg(0, 7, 2); wr(5'h08, 1);
    cfg(0, 3, 1); wr(5'h08, 1);
    rd_chk(5'h08, 32'h1, "R2");
    rd_chk(5'h14, 32'h0001_0003, "R2");
    wr(5'h00, 1);
    push_pat(0, 7, 2, 0, 2, "R9");
    drain();

    // R12 restart after stopping mid-cycle
    wr(5'h00, 0);
    wr(5'h00, 1);
    repeat (5) @(negedge clk);
    wr(5'h00, 0);
    wr(5'h00, 1);
    push_pat(0, 7, 2, 0, 2, "R12");
    drain();
    wr(5'h00, 0);
    wr(5'h08, 0);
    @(negedge clk); #1;
    check("R3", {31'b0, pwm_out}, 0);

    finish_up();
  end
endmodule